// File: doc/BRIEF.md
# DMX512 Frame Transmitter

This block drives a DMX512 lighting-control line without pause. It holds a value for every channel in a local slot store. For each frame it steps the line through a fixed sequence: an idle mark gap, a break that forces the line low, a short mark-after-break, one character carrying the start code, and then every slot value from channel 0 upward. A bit serializer timed by a clock-enable divider produces the characters. Each character is a low start bit, eight data bits sent least significant bit first, and two high stop bits.

A host changes channel values at any time through a one-cycle write port that carries a channel index and a data byte. Writes are never refused or stalled. A write takes effect no later than the next time that slot goes out. When the last slot of a frame has left the line, the block raises `frame_sent` for one clock cycle and begins the next idle gap.

All durations are counted in system clocks. The break and mark-after-break lengths come from microsecond parameters. The gap is a parameter in clocks. The bit period is CLK_HZ/BAUD clocks, which is 200 clocks for the default 250000 baud at 50 MHz.

Top module: `dmx_frame_tx`

## Requirements
- R1: While reset is held and after it is released, `tx_line` is high and `frame_sent` is low. Every slot value is zero, so the first frame carries only zero bytes.
- R2: Each character is a low start bit, then 8 data bits with bit 0 first, then 2 high stop bits. Every bit lasts CLK_HZ/BAUD clocks. Outside a break and outside a character, the line is high.
- R3: The break holds `tx_line` low for exactly BREAK_US × (CLK_HZ/1e6) clocks.
- R4: The mark-after-break holds `tx_line` high for exactly MAB_US × (CLK_HZ/1e6) clocks. The start bit of the first character follows it at once.
- R5: The first character after the mark-after-break carries the start code 0x00.
- R6: After the start code, the line sends SLOTS characters with the values of channels 0, 1, …, SLOTS-1 in ascending order, back to back, with no idle time between characters.
- R7: `frame_sent` is high for exactly one clock, in the cycle after the last stop bit ends. The line then stays high, and the next break begins GAP_CLKS clocks after that pulse.
- R8: A write (`wr_en` high for one clock, channel `wr_addr`, value `wr_data`) replaces the value of that channel in every frame that starts after the write.
- R9: A write is accepted in every cycle, including a run of writes on consecutive cycles while a frame is on the line. None is lost. Within the frame in progress, each slot shows either its old value or its new one. The next frame shows all the new values.
- R10: A write whose `wr_addr` is SLOTS or greater is discarded and changes no slot.
- R11: Frames repeat without end, each with the same break, mark-after-break and gap timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe, one value per cycle |
| wr_addr | input | $clog2(SLOTS) | Channel index of the write |
| wr_data | input | 8 | Channel value to store |
| tx_line | output | 1 | Serial DMX line, idles high |
| frame_sent | output | 1 | One-cycle pulse after the last slot of a frame |

## Verification
A wrong phase counter appears on the line within one frame: the break or the mark-after-break has the wrong length, which the bench measures to the clock. A slot index that skips or repeats shifts every later character of the same frame, so the first wrong byte points to the fault. A serializer that loses its bit count breaks the stop bits or the back-to-back spacing within one character time. A dropped or misrouted host write only becomes visible in the first frame that starts after the write, so the write scenarios always compare the complete frame that follows.

// File: rtl/dmx_tx_pkg.sv
package dmx_tx_pkg;

  typedef enum logic [1:0] {
    PH_GAP   = 2'd0,
    PH_BREAK = 2'd1,
    PH_MAB   = 2'd2,
    PH_SLOTS = 2'd3
  } phase_t;

  localparam logic [7:0] START_CODE = 8'h00;

  // system clocks held per serial bit
  function automatic int clks_per_bit(input int clk_hz, input int baud);
    int q;
    q = clk_hz / baud;
    return (q < 1) ? 1 : q;
  endfunction

  // microseconds converted to system clocks, never below one
  function automatic int us_to_clks(input int clk_hz, input int us);
    int q;
    q = (clk_hz / 1_000_000) * us;
    return (q < 1) ? 1 : q;
  endfunction

  // start bit + 8 data bits + stop bits
  function automatic int char_bits(input int stop_bits);
    return 1 + 8 + stop_bits;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/dmx_slot_store.sv
module dmx_slot_store #(
  parameter int SLOTS = 512,
  parameter int AW    = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);

  logic [7:0] mem [SLOTS];
  logic       wr_hit;

  // indices at or beyond the slot count are dropped
  assign wr_hit  = wr_en && ({1'b0, wr_addr} < (AW+1)'(SLOTS));
  assign rd_data = mem[rd_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) mem[i] <= '0;
    end else if (wr_hit) begin
      mem[wr_addr] <= wr_data;
    end
  end

endmodule

// File: rtl/dmx_bit_tick.sv
module dmx_bit_tick #(
  parameter int DIV = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);

  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;

  assign tick = (cnt == CW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt <= '0;
    else if (restart || tick) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/dmx_char_shifter.sv
module dmx_char_shifter import dmx_tx_pkg::*; #(
  parameter int CPB       = 200,
  parameter int STOP_BITS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] load_byte,
  output logic       line,
  output logic       busy,
  output logic       done
);

  localparam int NB = char_bits(STOP_BITS);
  localparam int BW = $clog2(NB);

  logic [NB-1:0] shreg;
  logic [BW-1:0] bitcnt;
  logic          tick;
  logic          last_bit;

  dmx_bit_tick #(.DIV(CPB)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (load),
    .tick    (tick)
  );

  assign last_bit = (bitcnt == BW'(NB - 1));
  assign done     = busy && tick && last_bit;
  assign line     = busy ? shreg[0] : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg  <= '1;
      bitcnt <= '0;
      busy   <= 1'b0;
    end else if (load) begin
      shreg  <= {{STOP_BITS{1'b1}}, load_byte, 1'b0};
      bitcnt <= '0;
      busy   <= 1'b1;
    end else if (busy && tick) begin
      shreg <= {1'b1, shreg[NB-1:1]};
      if (last_bit) busy   <= 1'b0;
      else          bitcnt <= bitcnt + 1'b1;
    end
  end

endmodule

// File: rtl/dmx_frame_tx.sv
module dmx_frame_tx import dmx_tx_pkg::*; #(
  parameter int CLK_HZ    = 50_000_000,
  parameter int BAUD      = 250_000,
  parameter int SLOTS     = 512,
  parameter int BREAK_US  = 92,
  parameter int MAB_US    = 12,
  parameter int GAP_CLKS  = 100,
  parameter int STOP_BITS = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [$clog2(SLOTS)-1:0] wr_addr,
  input  logic [7:0]               wr_data,
  output logic                     tx_line,
  output logic                     frame_sent
);

  localparam int AW         = $clog2(SLOTS);
  localparam int IW         = $clog2(SLOTS + 1);
  localparam int CPB        = clks_per_bit(CLK_HZ, BAUD);
  localparam int BREAK_CLKS = us_to_clks(CLK_HZ, BREAK_US);
  localparam int MAB_CLKS   = us_to_clks(CLK_HZ, MAB_US);
  localparam int GAP_LEN    = (GAP_CLKS < 1) ? 1 : GAP_CLKS;
  localparam int TW         = $clog2(max3(BREAK_CLKS, MAB_CLKS, GAP_LEN) + 1);

  phase_t        phase;
  logic [TW-1:0] tmr;
  logic [TW-1:0] phase_last;
  logic [IW-1:0] slot_idx;
  logic [7:0]    rd_data;
  logic [7:0]    char_byte;
  logic          phase_end;
  logic          slots_done;
  logic          char_load;
  logic          ser_line;
  logic          ser_busy;
  logic          ser_done;
  logic          in_break;
  logic          in_mab;
  logic          in_slots;

  // named internal events
  assign in_break   = (phase == PH_BREAK);
  assign in_mab     = (phase == PH_MAB);
  assign in_slots   = (phase == PH_SLOTS);
  assign slots_done = (slot_idx == IW'(SLOTS));
  assign phase_end  = !in_slots && (tmr == phase_last);
  assign char_load  = (in_mab && phase_end) || (in_slots && ser_done && !slots_done);
  assign char_byte  = in_mab ? START_CODE : rd_data;
  assign tx_line    = in_break ? 1'b0 : ser_line;

  always_comb begin
    case (phase)
      PH_GAP:   phase_last = TW'(GAP_LEN - 1);
      PH_BREAK: phase_last = TW'(BREAK_CLKS - 1);
      PH_MAB:   phase_last = TW'(MAB_CLKS - 1);
      default:  phase_last = '0;
    endcase
  end

  dmx_slot_store #(.SLOTS(SLOTS), .AW(AW)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (slot_idx[AW-1:0]),
    .rd_data (rd_data)
  );

  dmx_char_shifter #(.CPB(CPB), .STOP_BITS(STOP_BITS)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (char_load),
    .load_byte (char_byte),
    .line      (ser_line),
    .busy      (ser_busy),
    .done      (ser_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase      <= PH_GAP;
      tmr        <= '0;
      slot_idx   <= '0;
      frame_sent <= 1'b0;
    end else begin
      frame_sent <= 1'b0;
      case (phase)
        PH_GAP: begin
          if (phase_end) begin
            phase <= PH_BREAK;
            tmr   <= '0;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        PH_BREAK: begin
          if (phase_end) begin
            phase <= PH_MAB;
            tmr   <= '0;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        PH_MAB: begin
          if (phase_end) begin
            phase    <= PH_SLOTS;
            tmr      <= '0;
            slot_idx <= '0;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        default: begin
          if (ser_done) begin
            if (slots_done) begin
              phase      <= PH_GAP;
              frame_sent <= 1'b1;
            end else begin
              slot_idx <= slot_idx + 1'b1;
            end
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/dmx_frame_tx_chk.sv
module dmx_frame_tx_chk #(
  parameter int IW    = 10,
  parameter int SLOTS = 512
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx_line,
  input logic          frame_sent,
  input logic          in_break,
  input logic          in_mab,
  input logic          ser_busy,
  input logic          ser_done,
  input logic          char_load,
  input logic [IW-1:0] slot_idx
);

  AST_BREAK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    in_break |-> !tx_line); // R3

  AST_MAB_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    in_mab |-> tx_line); // R4

  AST_START_BIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    char_load |=> !tx_line); // R2

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_break && !ser_busy) |-> tx_line); // R2

  AST_NO_CHAR_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    char_load |-> (!ser_busy || ser_done)); // R6

  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(slot_idx) <= SLOTS); // R6

  AST_SENT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sent |=> !frame_sent); // R7

  AST_SENT_LINE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sent |-> (!ser_busy && !in_break && tx_line)); // R7

endmodule

bind dmx_frame_tx dmx_frame_tx_chk #(.IW(IW), .SLOTS(SLOTS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tx_line    (tx_line),
  .frame_sent (frame_sent),
  .in_break   (in_break),
  .in_mab     (in_mab),
  .ser_busy   (ser_busy),
  .ser_done   (ser_done),
  .char_load  (char_load),
  .slot_idx   (slot_idx)
);

// File: tb/dmx_frame_tx_bench.sv
module dmx_frame_tx_bench;

  localparam int SLOTS    = 6;
  localparam int AW       = 3;
  localparam int CLK_HZ   = 50_000_000;
  localparam int BAUD     = 12_500_000;
  localparam int BREAK_US = 1;
  localparam int MAB_US   = 1;
  localparam int GAP_CLKS = 10;
  // expectations restated from the requirements
  localparam int CPB     = CLK_HZ / BAUD;
  localparam int BRK_EXP = int'((longint'(CLK_HZ) * BREAK_US) / 1_000_000);
  localparam int MAB_EXP = int'((longint'(CLK_HZ) * MAB_US) / 1_000_000);
  localparam int TAIL    = CPB - CPB / 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]    wr_data = '0;
  wire           tx_line;
  wire           frame_sent;

  always #10 clk = ~clk;

  dmx_frame_tx #(
    .CLK_HZ(CLK_HZ), .BAUD(BAUD), .SLOTS(SLOTS), .BREAK_US(BREAK_US),
    .MAB_US(MAB_US), .GAP_CLKS(GAP_CLKS), .STOP_BITS(2)
  ) u_dmx_frame_tx (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .tx_line(tx_line), .frame_sent(frame_sent)
  );

  int         checks = 0;
  int         fails = 0;
  bit         finished = 1'b0;
  logic [7:0] shadow [SLOTS];
  logic [7:0] prev   [SLOTS];
  logic [7:0] got    [SLOTS+1];
  int         brk_len, mab_len, fmt_bad, spacing_bad, gap_len, sent_wait;
  bit         pulse_ok;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic rx_char(output logic [7:0] b, output int bad);
    bad = 0;
    b   = '0;
    repeat (CPB / 2) @(negedge clk);
    if (tx_line !== 1'b0) bad++;
    for (int i = 0; i < 8; i++) begin
      repeat (CPB) @(negedge clk);
      b[i] = tx_line;
    end
    for (int s = 0; s < 2; s++) begin
      repeat (CPB) @(negedge clk);
      if (tx_line !== 1'b1) bad++;
    end
  endtask

  // captures one frame; ends on the first low sample of the next break
  task automatic capture_frame();
    int n;
    int bad;
    brk_len = 0; mab_len = 0; fmt_bad = 0; spacing_bad = 0;
    gap_len = 0; pulse_ok = 1'b1;
    while (tx_line === 1'b1) @(negedge clk);
    while (tx_line === 1'b0) begin brk_len++; @(negedge clk); end
    while (tx_line === 1'b1) begin mab_len++; @(negedge clk); end
    for (int k = 0; k <= SLOTS; k++) begin
      rx_char(got[k], bad);
      fmt_bad += bad;
      if (k < SLOTS) begin
        n = 0;
        while (tx_line === 1'b1 && n < 1000) begin n++; @(negedge clk); end
        if (n != TAIL) spacing_bad++;
      end
    end
    n = 0;
    while (frame_sent !== 1'b1 && n < 1000) begin n++; @(negedge clk); end
    sent_wait = n;
    while (tx_line === 1'b1 && gap_len < 1000) begin
      @(negedge clk);
      gap_len++;
      if (gap_len == 1 && frame_sent !== 1'b0) pulse_ok = 1'b0;
    end
  endtask

  task automatic check_timing(input string tag);
    chk(brk_len == BRK_EXP, "R3", {tag, " break length"}, brk_len, BRK_EXP);
    chk(mab_len == MAB_EXP, "R4", {tag, " mark-after-break length"}, mab_len, MAB_EXP);
    chk(fmt_bad == 0, "R2", {tag, " start/stop bit errors"}, fmt_bad, 0);
    chk(spacing_bad == 0, "R6", {tag, " non back-to-back characters"}, spacing_bad, 0);
    chk(sent_wait == TAIL, "R7", {tag, " frame_sent delay after last stop bit"}, sent_wait, TAIL);
    chk(pulse_ok, "R7", {tag, " frame_sent width one cycle"}, int'(pulse_ok), 1);
    chk(gap_len == GAP_CLKS, "R7", {tag, " gap before next break"}, gap_len, GAP_CLKS);
  endtask

  task automatic check_data(input string req, input string tag);
    chk(got[0] == 8'h00, "R5", {tag, " start code"}, int'(got[0]), 0);
    for (int k = 0; k < SLOTS; k++)
      chk(got[k+1] == shadow[k], req, $sformatf("%s slot %0d", tag, k),
          int'(got[k+1]), int'(shadow[k]));
  endtask

  task automatic host_write(input int addr, input logic [7:0] val);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = AW'(addr);
    wr_data = val;
    @(negedge clk);
    wr_en = 1'b0;
    if (addr < SLOTS) shadow[addr] = val;
  endtask

  task automatic test_reset();
    chk(tx_line === 1'b1, "R1", "line high in reset", int'(tx_line), 1);
    chk(frame_sent === 1'b0, "R1", "frame_sent low in reset", int'(frame_sent), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tx_line === 1'b1, "R1", "line high after reset", int'(tx_line), 1);
    capture_frame();
    check_data("R1", "first frame zero");
    check_timing("first frame");
  endtask

  task automatic test_patterns();
    for (int k = 0; k < SLOTS; k++) host_write(k, 8'(8'h11 * (k + 1)));
    capture_frame();
    capture_frame();
    check_data("R8", "ascending pattern");
    check_timing("ascending pattern");
    host_write(0, 8'h01);
    host_write(1, 8'h80);
    host_write(2, 8'hFF);
    host_write(3, 8'h00);
    host_write(4, 8'hA5);
    host_write(5, 8'h5A);
    capture_frame();
    capture_frame();
    check_data("R2", "bit order pattern");
  endtask

  task automatic test_live_write();
    for (int k = 0; k < SLOTS; k++) prev[k] = shadow[k];
    fork
      capture_frame();
      begin
        repeat (170) @(negedge clk);
        for (int k = 0; k < SLOTS; k++) begin
          wr_en   = 1'b1;
          wr_addr = AW'(k);
          wr_data = 8'(8'hC3 ^ (k * 8'h17));
          shadow[k] = wr_data;
          @(negedge clk);
        end
        wr_en = 1'b0;
      end
    join
    for (int k = 0; k < SLOTS; k++)
      chk(got[k+1] == prev[k] || got[k+1] == shadow[k], "R9",
          $sformatf("slot %0d old or new during write burst", k),
          int'(got[k+1]), int'(shadow[k]));
    capture_frame();
    check_data("R9", "frame after write burst");
  endtask

  task automatic test_out_of_range();
    for (int a = SLOTS; a < (1 << AW); a++) host_write(a, 8'hEE);
    capture_frame();
    capture_frame();
    check_data("R10", "after out-of-range writes");
  endtask

  task automatic test_repeat();
    for (int f = 0; f < 3; f++) begin
      capture_frame();
      check_timing($sformatf("R11 repeat %0d", f));
      check_data("R11", $sformatf("repeat %0d", f));
    end
  endtask

  initial begin
    for (int k = 0; k < SLOTS; k++) shadow[k] = 8'h00;
    repeat (4) @(negedge clk);
    test_reset();
    test_patterns();
    test_live_write();
    test_out_of_range();
    test_repeat();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL R11 watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule